// File: doc/BRIEF.md
# Translation Table Geometry Calculator

This block turns the raw 64-bit descriptor words of a set of translation tables into ready-to-use geometry. On a single-cycle start strobe it captures every descriptor slot, the command queue descriptor and the ID-width settings. It then walks the slots one per cycle and routes each one by its kind field. A device-kind slot drives the device-table outputs and a collection-kind slot drives the collection-table outputs. For each routed table it reports a valid flag, the usable entry count, the physical base address and the ID limit. The command queue's entry count and base are produced at the start strobe.

The control is a three-state machine. ST_IDLE waits for a strobe; the launch transition (ST_IDLE to ST_SCAN) snapshots the inputs. ST_SCAN stays in place through the advance transition, one slot per cycle. The finish transition (ST_SCAN to ST_REPORT) follows the last slot. ST_REPORT raises the done pulse for one cycle and the retire transition returns the machine to ST_IDLE.

Entry sizes are powers of two, written as a base-2 logarithm, so every division becomes a shift. A two-level table counts level-1 pointers of 8 bytes, each of which leads to one full page of entries. Command slots are 32 bytes.

Top module: `tgc_geometry`

## Requirements
- R1: Descriptor bits [11:10] select the page: 0 gives 4 KB, 1 gives 16 KB, and 2 or 3 give 64 KB. Bits [7:0] hold the page count minus one. Bits [50:48] hold log2 of the entry size in bytes.
- R2: When bit 62 (two-level) is clear, the entry count is pages times page bytes divided by entry bytes.
- R3: When bit 62 is set, the entry count is (pages times page bytes / 8) times (page bytes / entry bytes).
- R4: For 4 KB and 16 KB pages, the base address is descriptor bits [47:12] placed at bit 12.
- R5: For 64 KB pages, the base address is bits [47:16] placed at bit 16, ORed with bits [15:12] placed at bit 48.
- R6: A valid device table reports an ID limit of 2^(devid_bits+1).
- R7: A valid collection table reports an ID limit of 2^(cid_bits+1) when cid_limited is 1, and 2^16 otherwise.
- R8: The command queue descriptor has valid bit 63, address bits [51:12] placed at bit 12, and page count minus one in bits [7:0]. Its entry count is (size+1)×4096/32.
- R9: A descriptor whose bit 63 (valid) is clear gives valid 0 and zero for the entry count, the base and the ID limit of its table.
- R10: Kind bits [58:56] route a slot: 1 goes to the device outputs and 4 to the collection outputs. Any other kind is ignored. When several slots share a kind, the highest-numbered slot wins. A kind with no slot reports valid 0 and zeros.
- R11: If start is sampled in ST_IDLE at clock edge n, done is high for exactly one cycle, after edge n+NUM_SLOTS, and every output holds its final value at that point.
- R12: A start strobe during a calculation is ignored. Input changes after the strobe have no effect on that calculation. While the block is idle, every output holds its value.
- R13: After reset every output is zero and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Calculation strobe |
| desc_bus | input | NUM_SLOTS*64 | Table descriptors, slot s at bits [s*64+63:s*64] |
| cmdq_desc | input | 64 | Command queue descriptor |
| devid_bits | input | DEVB_W | Device ID width field |
| cid_bits | input | CIDB_W | Collection ID width field |
| cid_limited | input | 1 | Collection ID width field is in use |
| done | output | 1 | Results ready pulse |
| dev_valid | output | 1 | Device table valid |
| dev_entries | output | CNT_W | Device table entry count |
| dev_base | output | 52 | Device table base address |
| dev_id_limit | output | DEVL_W | Device ID limit |
| col_valid | output | 1 | Collection table valid |
| col_entries | output | CNT_W | Collection table entry count |
| col_base | output | 52 | Collection table base address |
| col_id_limit | output | COLL_W | Collection ID limit |
| cq_valid | output | 1 | Command queue valid |
| cq_entries | output | CNT_W | Command queue entry count |
| cq_base | output | 52 | Command queue base address |

## Verification
A slot index that drifts or a state that is held too long shows up as a done pulse arriving off its edge. It can also show up as a table's outputs taken from the wrong slot, visible in the cycle of that done pulse. A mistake in the shift amount gives an entry count that is off by a power of two, and it shows the moment the routed slot is decoded. A snapshot that fails to latch, or a start that is not masked while busy, lets later input changes leak into the results or produces a second done pulse. Both appear within one calculation.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
    localparam int DESC_W   = 64;
    localparam int ADDR_W   = 52;
    // table descriptor field layout
    localparam int VALID_BIT = 63;
    localparam int IND_BIT   = 62;
    localparam int TYPE_LO   = 56;
    localparam int TYPE_W    = 3;
    localparam int ESZ_LO    = 48;
    localparam int ESZ_W     = 3;
    localparam int PA_LO     = 12;
    localparam int PA_W      = 36;
    localparam int PG_LO     = 10;
    localparam int PG_W      = 2;
    localparam int SIZE_LO   = 0;
    localparam int SIZE_W    = 8;
    // split address for the largest page
    localparam int HI64_W    = 4;
    localparam int LO64_SH   = 16;
    localparam int HI64_SH   = 48;
    // fixed geometry constants (log2 of bytes)
    localparam int L1_LOG     = 3;
    localparam int CMD_LOG    = 5;
    localparam int PAGE4K_LOG = 12;
    // command queue address field
    localparam int CQ_PA_LO = 12;
    localparam int CQ_PA_W  = 40;
    // slot kinds
    localparam logic [TYPE_W-1:0] KIND_DEVICE = 3'd1;
    localparam logic [TYPE_W-1:0] KIND_COLL   = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_REPORT
    } phase_e;
endpackage

// File: rtl/tgc_tbl_decode.sv
module tgc_tbl_decode
    import tgc_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic [DESC_W-1:0] desc,
    output logic              valid,
    output logic [CNT_W-1:0]  entries,
    output logic [ADDR_W-1:0] base
);
    localparam int SH_W = 6;

    logic [SH_W-1:0] pg_sh;
    logic [SH_W-1:0] esz_sh;
    logic [SH_W-1:0] amt;
    logic [SIZE_W:0] pages;
    logic            big_page;

    always_comb begin
        unique case (desc[PG_LO +: PG_W])
            2'd0:    pg_sh = SH_W'(12);
            2'd1:    pg_sh = SH_W'(14);
            default: pg_sh = SH_W'(16);
        endcase
        big_page = desc[PG_LO + 1];
        esz_sh   = SH_W'(desc[ESZ_LO +: ESZ_W]);
        pages    = {1'b0, desc[SIZE_LO +: SIZE_W]} + (SIZE_W + 1)'(1);
        if (desc[IND_BIT]) begin
            amt = pg_sh + pg_sh - SH_W'(L1_LOG) - esz_sh;
        end else begin
            amt = pg_sh - esz_sh;
        end
        valid = desc[VALID_BIT];
        if (!valid) begin
            entries = '0;
            base    = '0;
        end else begin
            entries = CNT_W'(pages) << amt;
            if (big_page) begin
                base = (ADDR_W'(desc[PA_LO + HI64_W +: PA_W - HI64_W]) << LO64_SH)
                     | (ADDR_W'(desc[PA_LO +: HI64_W]) << HI64_SH);
            end else begin
                base = ADDR_W'(desc[PA_LO +: PA_W]) << PA_LO;
            end
        end
    end
endmodule

// File: rtl/tgc_cmdq_decode.sv
module tgc_cmdq_decode
    import tgc_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic [DESC_W-1:0] desc,
    output logic              valid,
    output logic [CNT_W-1:0]  entries,
    output logic [ADDR_W-1:0] base
);
    logic [SIZE_W:0] pages;

    always_comb begin
        valid = desc[VALID_BIT];
        pages = {1'b0, desc[SIZE_LO +: SIZE_W]} + (SIZE_W + 1)'(1);
        if (valid) begin
            entries = CNT_W'(pages) << (PAGE4K_LOG - CMD_LOG);
            base    = ADDR_W'(desc[CQ_PA_LO +: CQ_PA_W]) << CQ_PA_LO;
        end else begin
            entries = '0;
            base    = '0;
        end
    end
endmodule

// File: rtl/tgc_geometry.sv
module tgc_geometry
    import tgc_pkg::*;
#(
    parameter int NUM_SLOTS     = 8,
    parameter int CNT_W         = 40,
    parameter int DEVB_W        = 5,
    parameter int CIDB_W        = 4,
    parameter int COL_FIXED_LOG = 16,
    localparam int DEVL_W = (1 << DEVB_W) + 1,
    localparam int COLL_W = (((1 << CIDB_W) > COL_FIXED_LOG) ? (1 << CIDB_W) : COL_FIXED_LOG) + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NUM_SLOTS*DESC_W-1:0] desc_bus,
    input  logic [DESC_W-1:0]           cmdq_desc,
    input  logic [DEVB_W-1:0]           devid_bits,
    input  logic [CIDB_W-1:0]           cid_bits,
    input  logic                        cid_limited,
    output logic                        done,
    output logic                        dev_valid,
    output logic [CNT_W-1:0]            dev_entries,
    output logic [ADDR_W-1:0]           dev_base,
    output logic [DEVL_W-1:0]           dev_id_limit,
    output logic                        col_valid,
    output logic [CNT_W-1:0]            col_entries,
    output logic [ADDR_W-1:0]           col_base,
    output logic [COLL_W-1:0]           col_id_limit,
    output logic                        cq_valid,
    output logic [CNT_W-1:0]            cq_entries,
    output logic [ADDR_W-1:0]           cq_base
);
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);
    localparam int DSH_W = DEVB_W + 1;
    localparam int CSH_W = CIDB_W + 1;

    phase_e           state_q;
    phase_e           state_d;
    logic [IDX_W-1:0] idx_q;
    logic             launch;

    assign launch = (state_q == ST_IDLE) && start;

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                idx_q <= '0;
            end else if (state_q == ST_SCAN) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // ---- next state ----
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SCAN;
            ST_SCAN:   if (idx_q == LAST_IDX) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---- descriptor snapshot, one register per slot ----
    logic [DESC_W-1:0] slot_w [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [DESC_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (launch) begin
                word_q <= desc_bus[g*DESC_W +: DESC_W];
            end
        end
        assign slot_w[g] = word_q;
    end

    logic [DESC_W-1:0] cur;
    logic [TYPE_W-1:0] cur_kind;
    assign cur      = slot_w[idx_q];
    assign cur_kind = cur[TYPE_LO +: TYPE_W];

    logic              t_valid;
    logic [CNT_W-1:0]  t_entries;
    logic [ADDR_W-1:0] t_base;
    logic              q_valid;
    logic [CNT_W-1:0]  q_entries;
    logic [ADDR_W-1:0] q_base;

    tgc_tbl_decode #(.CNT_W(CNT_W)) u_tbl (
        .desc    (cur),
        .valid   (t_valid),
        .entries (t_entries),
        .base    (t_base)
    );

    tgc_cmdq_decode #(.CNT_W(CNT_W)) u_cq (
        .desc    (cmdq_desc),
        .valid   (q_valid),
        .entries (q_entries),
        .base    (q_base)
    );

    // ---- ID limits from the strobe-time settings ----
    logic [DSH_W-1:0]  dev_sh;
    logic [CSH_W-1:0]  col_sh;
    logic [DEVL_W-1:0] dev_lim_d;
    logic [COLL_W-1:0] col_lim_d;
    logic [DEVL_W-1:0] dev_lim_hold;
    logic [COLL_W-1:0] col_lim_hold;

    always_comb begin
        dev_sh    = {1'b0, devid_bits} + DSH_W'(1);
        col_sh    = {1'b0, cid_bits} + CSH_W'(1);
        dev_lim_d = DEVL_W'(1) << dev_sh;
        col_lim_d = cid_limited ? (COLL_W'(1) << col_sh) : (COLL_W'(1) << COL_FIXED_LOG);
    end

    // ---- result registers ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_valid    <= 1'b0;
            dev_entries  <= '0;
            dev_base     <= '0;
            dev_id_limit <= '0;
            col_valid    <= 1'b0;
            col_entries  <= '0;
            col_base     <= '0;
            col_id_limit <= '0;
            cq_valid     <= 1'b0;
            cq_entries   <= '0;
            cq_base      <= '0;
            dev_lim_hold <= '0;
            col_lim_hold <= '0;
        end else if (launch) begin
            dev_valid    <= 1'b0;
            dev_entries  <= '0;
            dev_base     <= '0;
            dev_id_limit <= '0;
            col_valid    <= 1'b0;
            col_entries  <= '0;
            col_base     <= '0;
            col_id_limit <= '0;
            cq_valid     <= q_valid;
            cq_entries   <= q_entries;
            cq_base      <= q_base;
            dev_lim_hold <= dev_lim_d;
            col_lim_hold <= col_lim_d;
        end else if (state_q == ST_SCAN) begin
            if (cur_kind == KIND_DEVICE) begin
                dev_valid    <= t_valid;
                dev_entries  <= t_entries;
                dev_base     <= t_base;
                dev_id_limit <= t_valid ? dev_lim_hold : '0;
            end
            if (cur_kind == KIND_COLL) begin
                col_valid    <= t_valid;
                col_entries  <= t_entries;
                col_base     <= t_base;
                col_id_limit <= t_valid ? col_lim_hold : '0;
            end
        end
    end

    // ---- state outputs ----
    always_comb begin
        done = (state_q == ST_REPORT);
    end
endmodule

// File: rtl/tgc_geometry_chk.sv
module tgc_geometry_chk #(
    parameter int NUM_SLOTS = 8,
    parameter int CNT_W     = 40,
    parameter int DEVL_W    = 33,
    parameter int COLL_W    = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              dev_valid,
    input logic [CNT_W-1:0]  dev_entries,
    input logic [51:0]       dev_base,
    input logic [DEVL_W-1:0] dev_id_limit,
    input logic              col_valid,
    input logic [CNT_W-1:0]  col_entries,
    input logic [51:0]       col_base,
    input logic [COLL_W-1:0] col_id_limit,
    input logic              cq_valid,
    input logic [CNT_W-1:0]  cq_entries,
    input logic [51:0]       cq_base
);
    localparam int CW = $clog2(NUM_SLOTS + 2) + 1;

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q && start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (done) busy_q <= 1'b0;
        end
    end

    assert_done_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_q && cnt_q == CW'(NUM_SLOTS)));
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start) |=> ($stable(dev_entries) && $stable(dev_base) && $stable(col_entries)
                                 && $stable(col_base) && $stable(cq_entries) && $stable(cq_base)));
    assert_dev_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_valid |-> (dev_entries == '0 && dev_base == '0 && dev_id_limit == '0));
    assert_col_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |-> (col_entries == '0 && col_base == '0 && col_id_limit == '0));
    assert_cq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cq_valid |-> (cq_entries == '0 && cq_base == '0));
    assert_dev_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid |-> ($countones(dev_id_limit) == 1 && !dev_id_limit[0]));
    assert_col_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> ($countones(col_id_limit) == 1 && !col_id_limit[0]));
    assert_cq_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cq_valid |-> (cq_entries[6:0] == '0 && cq_entries != '0 && cq_base[11:0] == '0));
    assert_base_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid |-> (dev_base[11:0] == '0 && dev_entries != '0));
endmodule

bind tgc_geometry tgc_geometry_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .CNT_W     (CNT_W),
    .DEVL_W    (DEVL_W),
    .COLL_W    (COLL_W)
) u_chk (.*);

// File: tb/tgc_geometry_bench.sv
`timescale 1ns/1ps
module tgc_geometry_bench;
    localparam int NS = 8;
    localparam int CW = 40;

    typedef struct packed {
        logic        ind;
        logic [2:0]  esz;
        logic [1:0]  pg;
        logic [7:0]  size;
        logic [35:0] pa;
        logic [39:0] exp_n;
        logic [51:0] exp_base;
    } vec_t;

    // hand-computed from R1..R5
    localparam vec_t VECS [0:6] = '{
        '{1'b0, 3'd3, 2'd0, 8'd0,   36'h000000001, 40'd512,        52'h0000000001000},
        '{1'b0, 3'd4, 2'd1, 8'd3,   36'h123456789, 40'd4096,       52'h0123456789000},
        '{1'b0, 3'd5, 2'd2, 8'd1,   36'hABCDE1234, 40'd4096,       52'h4ABCDE1230000},
        '{1'b1, 3'd3, 2'd3, 8'd0,   36'h000000010, 40'h0004000000, 52'h0000000010000},
        '{1'b1, 3'd2, 2'd0, 8'd255, 36'hFFFFFFFFF, 40'h0008000000, 52'h0FFFFFFFFF000},
        '{1'b1, 3'd7, 2'd1, 8'd7,   36'h000000000, 40'h0000200000, 52'h0000000000000},
        '{1'b1, 3'd0, 2'd2, 8'd255, 36'hFFFFFFFFF, 40'h2000000000, 52'hFFFFFFFFF0000}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n;
    logic             start;
    logic [NS*64-1:0] desc_bus;
    logic [63:0]      cmdq_desc;
    logic [4:0]       devid_bits;
    logic [3:0]       cid_bits;
    logic             cid_limited;
    logic             done;
    logic             dev_valid, col_valid, cq_valid;
    logic [CW-1:0]    dev_entries, col_entries, cq_entries;
    logic [51:0]      dev_base, col_base, cq_base;
    logic [32:0]      dev_id_limit;
    logic [16:0]      col_id_limit;

    tgc_geometry u_tgc_geometry (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_bus(desc_bus), .cmdq_desc(cmdq_desc),
        .devid_bits(devid_bits), .cid_bits(cid_bits), .cid_limited(cid_limited), .done(done),
        .dev_valid(dev_valid), .dev_entries(dev_entries), .dev_base(dev_base), .dev_id_limit(dev_id_limit),
        .col_valid(col_valid), .col_entries(col_entries), .col_base(col_base), .col_id_limit(col_id_limit),
        .cq_valid(cq_valid), .cq_entries(cq_entries), .cq_base(cq_base)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] mk_desc(input logic v, input logic ind, input logic [2:0] kind,
                                            input logic [2:0] esz, input logic [35:0] pa,
                                            input logic [1:0] pg, input logic [7:0] size);
        logic [63:0] d;
        d = '0;
        d[63] = v; d[62] = ind; d[58:56] = kind; d[50:48] = esz;
        d[47:12] = pa; d[11:10] = pg; d[7:0] = size;
        return d;
    endfunction

    function automatic logic [63:0] mk_cq(input logic v, input logic [39:0] pa, input logic [7:0] size);
        logic [63:0] d;
        d = '0;
        d[63] = v; d[51:12] = pa; d[7:0] = size;
        return d;
    endfunction

    task automatic launch(output int lat);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #1_900_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lat;
        int cs;
        vec_t v;
        logic [39:0] qpa;
        logic [63:0] exp_col;
        logic [63:0] keep_n;
        logic [63:0] keep_q;

        rst_n = 1'b0; start = 1'b0; desc_bus = '0; cmdq_desc = '0;
        devid_bits = '0; cid_bits = '0; cid_limited = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        chk("R13 done", 64'(done), 64'd0);
        chk("R13 dev_valid", 64'(dev_valid), 64'd0);
        chk("R13 dev_entries", 64'(dev_entries), 64'd0);
        chk("R13 col_id_limit", 64'(col_id_limit), 64'd0);
        chk("R13 cq_base", 64'(cq_base), 64'd0);

        // vector table: device in slot i, collection in slot (i+3)%8
        for (int i = 0; i < 7; i++) begin
            v  = VECS[i];
            cs = (i + 3) % NS;
            qpa = 40'h0012345670 + 40'(i);
            desc_bus = '0;
            desc_bus[i*64 +: 64]  = mk_desc(1'b1, v.ind, 3'd1, v.esz, v.pa, v.pg, v.size);
            desc_bus[cs*64 +: 64] = mk_desc(1'b1, v.ind, 3'd4, v.esz, v.pa, v.pg, v.size);
            cmdq_desc   = mk_cq(1'b1, qpa, 8'(i * 40));
            devid_bits  = 5'(i * 4);
            cid_limited = i[0];
            cid_bits    = 4'(i + 9);
            exp_col     = cid_limited ? (64'd1 << (i + 10)) : 64'd65536;
            launch(lat);
            chk($sformatf("R11 vec%0d latency", i), 64'(lat), 64'd9);
            chk($sformatf("R10 vec%0d dev_valid", i), 64'(dev_valid), 64'd1);
            chk($sformatf("R1 %s vec%0d dev_entries", v.ind ? "R3" : "R2", i), 64'(dev_entries), 64'(v.exp_n));
            chk($sformatf("%s vec%0d dev_base", v.pg[1] ? "R5" : "R4", i), 64'(dev_base), 64'(v.exp_base));
            chk($sformatf("R6 vec%0d dev_id_limit", i), 64'(dev_id_limit), 64'd1 << (i * 4 + 1));
            chk($sformatf("R10 vec%0d col_valid", i), 64'(col_valid), 64'd1);
            chk($sformatf("R10 vec%0d col_entries", i), 64'(col_entries), 64'(v.exp_n));
            chk($sformatf("R10 vec%0d col_base", i), 64'(col_base), 64'(v.exp_base));
            chk($sformatf("R7 vec%0d col_id_limit", i), 64'(col_id_limit), exp_col);
            chk($sformatf("R8 vec%0d cq_valid", i), 64'(cq_valid), 64'd1);
            chk($sformatf("R8 vec%0d cq_entries", i), 64'(cq_entries), 64'((i * 40 + 1) * 128));
            chk($sformatf("R8 vec%0d cq_base", i), 64'(cq_base), 64'(qpa) << 12);
            @(negedge clk);
            chk($sformatf("R11 vec%0d done low after pulse", i), 64'(done), 64'd0);
        end

        // R9 invalid descriptors clear their outputs
        desc_bus = '0;
        desc_bus[0*64 +: 64] = mk_desc(1'b0, 1'b0, 3'd1, 3'd3, 36'h55, 2'd1, 8'd9);
        desc_bus[1*64 +: 64] = mk_desc(1'b1, 1'b0, 3'd4, 3'd3, 36'h1, 2'd0, 8'd0);
        cmdq_desc  = mk_cq(1'b0, 40'hABCD, 8'd5);
        devid_bits = 5'd3; cid_limited = 1'b0;
        launch(lat);
        chk("R9 dev_valid", 64'(dev_valid), 64'd0);
        chk("R9 dev_entries", 64'(dev_entries), 64'd0);
        chk("R9 dev_base", 64'(dev_base), 64'd0);
        chk("R9 dev_id_limit", 64'(dev_id_limit), 64'd0);
        chk("R9 col unaffected entries", 64'(col_entries), 64'd512);
        chk("R9 col unaffected limit", 64'(col_id_limit), 64'd65536);
        chk("R9 cq_valid", 64'(cq_valid), 64'd0);
        chk("R9 cq_entries", 64'(cq_entries), 64'd0);
        chk("R9 cq_base", 64'(cq_base), 64'd0);

        // R10 other kinds ignored, highest slot wins, missing kind reports zero
        desc_bus = '0;
        desc_bus[2*64 +: 64] = mk_desc(1'b1, 1'b0, 3'd1, 3'd3, 36'h1, 2'd0, 8'd0);
        desc_bus[4*64 +: 64] = mk_desc(1'b1, 1'b0, 3'd2, 3'd5, 36'hABCDE1234, 2'd2, 8'd1);
        desc_bus[5*64 +: 64] = mk_desc(1'b1, 1'b1, 3'd7, 3'd0, 36'h7, 2'd2, 8'd3);
        desc_bus[6*64 +: 64] = mk_desc(1'b1, 1'b0, 3'd1, 3'd4, 36'h123456789, 2'd1, 8'd3);
        cmdq_desc = mk_cq(1'b1, 40'h1, 8'd0);
        launch(lat);
        chk("R10 later slot wins entries", 64'(dev_entries), 64'd4096);
        chk("R10 later slot wins base", 64'(dev_base), 64'h0123456789000);
        chk("R10 no collection valid", 64'(col_valid), 64'd0);
        chk("R10 no collection entries", 64'(col_entries), 64'd0);

        // R12 start while busy ignored, inputs after strobe ignored
        desc_bus = '0;
        desc_bus[0*64 +: 64] = mk_desc(1'b1, 1'b0, 3'd1, 3'd3, 36'h1, 2'd0, 8'd0);
        cmdq_desc = mk_cq(1'b1, 40'h2, 8'd1);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; lat = 1;
        @(negedge clk); lat++;
        start = 1'b1;
        desc_bus[0*64 +: 64] = mk_desc(1'b1, 1'b0, 3'd1, 3'd4, 36'h123456789, 2'd1, 8'd3);
        cmdq_desc = mk_cq(1'b1, 40'h9, 8'd9);
        @(negedge clk); lat++; start = 1'b0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R12 latency with extra strobe", 64'(lat), 64'd9);
        chk("R12 snapshot dev_entries", 64'(dev_entries), 64'd512);
        chk("R12 snapshot cq_entries", 64'(cq_entries), 64'd256);
        keep_n = 64'(dev_entries);
        keep_q = 64'(cq_base);
        begin
            int extra;
            extra = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk("R12 no second done", 64'(extra), 64'd0);
        end
        chk("R12 idle hold dev_entries", 64'(dev_entries), keep_n);
        chk("R12 idle hold cq_base", 64'(cq_base), keep_q);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule